// File: doc/BRIEF.md
# Slope-Selectable Digital Level Trigger

The block watches a stream of unsigned converter words and raises a one-clock compare pulse when the stream crosses a programmed threshold in a chosen direction. It does not fire merely because a word lies on one side of the threshold. A crossing needs two consecutive accepted words, one on each side. The pulse starts an acquisition sequence held elsewhere. The threshold and the direction come in one bit at a time as a field of a larger serial control word.

The threshold compare is built from cascaded narrow magnitude stages. The stage width is a parameter, and the data width must be a whole multiple of it. After firing, the trigger disarms itself, so it fires at most once per run. It stays silent until software pulses `arm` again.

The word input is a valid/ready stream. `s_ready` is held high after reset, so the block never applies back-pressure. A word counts as transferred in every cycle in which `s_valid` is high. Words in cycles without `s_valid` are not seen, and the stream history is not changed by them.

Top module: `level_trigger`

## Requirements
- R1: Each cycle with `cfg_shift` high shifts `cfg_bit` into a DATA_W+1 bit register. After DATA_W+1 shifts:
  - the first bit shifted in selects the slope: 1 is rising, 0 is falling;
  - the following DATA_W bits are the threshold, most significant bit first.
  
  With `cfg_shift` low, the register holds its value.
- R2: The threshold compare treats both the word and the threshold as unsigned.
- R3: With falling slope, `trig_fire` is high for an accepted word below the threshold when the previous accepted word was at or above it.
- R4: With rising slope, `trig_fire` is high for an accepted word above the threshold when the previous accepted word was at or below it.
- R5: No pulse occurs for any other pair of consecutive words. This covers staying on one side, landing exactly on the threshold, and crossing in the unselected direction.
- R6: The first accepted word after arming never fires.
- R7: After a pulse, `trig_armed` is low from the next cycle on. No further pulse occurs until `arm` is pulsed again.
- R8: `trig_fire` is combinational with the accepted word that completes the crossing. It is high only in a cycle with `s_valid` high and lasts one clock per such word.
- R9: Idle cycles between two accepted words do not break a crossing.
- R10: Reset leaves the block disarmed, with the threshold at 0, falling slope, and `s_ready` high. A word presented in the same cycle as `arm` is discarded and is not used as history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift | input | 1 | Shift-enable for the serial configuration field |
| cfg_bit | input | 1 | Serial configuration data bit |
| arm | input | 1 | One-cycle pulse that arms the trigger and clears its history |
| s_valid | input | 1 | Converter word valid |
| s_ready | output | 1 | Always high after reset (no back-pressure) |
| s_data | input | DATA_W | Unsigned converter word |
| trig_fire | output | 1 | Compare pulse marking a crossing |
| trig_armed | output | 1 | High while the trigger waits for a crossing |

## Verification
The bench runs every ordered pair from a grid of word values for both slopes and several thresholds, including 0 and full scale. The grid always contains threshold-1, the threshold itself and threshold+1, so it catches:
- a signed compare;
- a crossing taken as a static level test;
- at-or-above confused with above.

Further sequences target the following faults:
- a design that fires on the first word after arming;
- a design that refires after a pulse;
- a design that loses its history across idle cycles;
- a design that wrongly records the word presented with `arm`.

// File: rtl/level_trigger_pkg.sv
package level_trigger_pkg;
  typedef enum logic {
    SLOPE_FALL = 1'b0,
    SLOPE_RISE = 1'b1
  } slope_e;
endpackage

// File: rtl/trig_cfg_shreg.sv
module trig_cfg_shreg
  import level_trigger_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_shift,
  input  logic              cfg_bit,
  output logic [DATA_W-1:0] level,
  output slope_e            slope
);
  localparam int REG_W = DATA_W + 1;

  logic [REG_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         sreg_q <= '0;
    else if (cfg_shift) sreg_q <= {sreg_q[REG_W-2:0], cfg_bit};
  end

  assign level = sreg_q[DATA_W-1:0];
  assign slope = slope_e'(sreg_q[REG_W-1]);

  // R1: a shifted bit lands in the low position
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift |=> sreg_q[0] == $past(cfg_bit));
  // R1: register holds while not shifting
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift |=> $stable(sreg_q));
endmodule

// File: rtl/trig_mag_compare.sv
module trig_mag_compare #(
  parameter int DATA_W  = 16,
  parameter int STAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              a_gt_b,
  output logic              a_lt_b
);
  localparam int NSTG = DATA_W / STAGE_W;

  // stage i covers bits [i*STAGE_W +: STAGE_W]; chain runs LSB stage upward
  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    logic [STAGE_W-1:0] sa, sb;
    logic gt_here, lt_here, gt_out, lt_out;
    assign sa      = a[i*STAGE_W +: STAGE_W];
    assign sb      = b[i*STAGE_W +: STAGE_W];
    assign gt_here = sa > sb;
    assign lt_here = sa < sb;
    if (i == 0) begin : g_first
      assign gt_out = gt_here;
      assign lt_out = lt_here;
    end else begin : g_next
      assign gt_out = gt_here | (!gt_here && !lt_here && g_stage[i-1].gt_out);
      assign lt_out = lt_here | (!gt_here && !lt_here && g_stage[i-1].lt_out);
    end
  end

  assign a_gt_b = g_stage[NSTG-1].gt_out;
  assign a_lt_b = g_stage[NSTG-1].lt_out;

  // R2: greater and less never both true
  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_gt_b && a_lt_b));
  // R2: neither flag means the operands are equal
  p_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_gt_b && !a_lt_b) |-> (a == b));
endmodule

// File: rtl/trig_cross_detect.sv
module trig_cross_detect
  import level_trigger_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   arm,
  input  logic   word_valid,
  input  logic   cur_gt,
  input  logic   cur_lt,
  input  slope_e slope,
  output logic   fire,
  output logic   armed
);
  logic armed_q, have_prev_q, prev_gt_q, prev_lt_q;
  logic take, cross_fall, cross_rise, hit;

  assign take       = word_valid && !arm && armed_q;
  assign cross_fall = !prev_lt_q && cur_lt;
  assign cross_rise = !prev_gt_q && cur_gt;
  assign hit        = (slope == SLOPE_RISE) ? cross_rise : cross_fall;
  assign fire       = take && have_prev_q && hit;
  assign armed      = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      have_prev_q <= 1'b0;
      prev_gt_q   <= 1'b0;
      prev_lt_q   <= 1'b0;
    end else if (arm) begin
      armed_q     <= 1'b1;
      have_prev_q <= 1'b0;
    end else if (fire) begin
      armed_q     <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (take) begin
      have_prev_q <= 1'b1;
      prev_gt_q   <= cur_gt;
      prev_lt_q   <= cur_lt;
    end
  end

  // R6: the word after an arm pulse cannot fire
  p_first_word_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !fire);
  // R7: a pulse disarms
  p_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q);
  // R7: silent while disarmed
  p_quiet_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !fire);
  // R8: a pulse only with an accepted word
  p_fire_with_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> word_valid);
endmodule

// File: rtl/level_trigger.sv
module level_trigger
  import level_trigger_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int STAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_shift,
  input  logic              cfg_bit,
  input  logic              arm,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              trig_fire,
  output logic              trig_armed
);
  logic [DATA_W-1:0] level;
  slope_e            slope;
  logic              cur_gt, cur_lt;
  logic              ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b1;
    else        ready_q <= 1'b1;
  end
  assign s_ready = ready_q;

  trig_cfg_shreg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .level(level), .slope(slope)
  );

  trig_mag_compare #(.DATA_W(DATA_W), .STAGE_W(STAGE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .a(s_data), .b(level),
    .a_gt_b(cur_gt), .a_lt_b(cur_lt)
  );

  trig_cross_detect u_cross (
    .clk(clk), .rst_n(rst_n), .arm(arm), .word_valid(s_valid && ready_q),
    .cur_gt(cur_gt), .cur_lt(cur_lt), .slope(slope),
    .fire(trig_fire), .armed(trig_armed)
  );

  // R10: never back-pressure after reset
  p_ready_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready);
  // R7: fire leaves armed low next cycle at the top level
  p_top_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> !trig_armed);
endmodule

// File: tb/level_trigger_bench.sv
module level_trigger_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_shift = 1'b0, cfg_bit = 1'b0, arm = 1'b0, s_valid = 1'b0;
  logic [W-1:0] s_data = '0;
  logic s_ready, trig_fire, trig_armed;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  level_trigger #(.DATA_W(W), .STAGE_W(4)) u_level_trigger (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .arm(arm), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .trig_fire(trig_fire), .trig_armed(trig_armed)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input bit rise, input int lvl);
    @(negedge clk);
    cfg_shift = 1'b1; cfg_bit = rise;
    for (int k = W - 1; k >= 0; k--) begin
      @(negedge clk);
      cfg_bit = lvl[k];
    end
    @(negedge clk);
    cfg_shift = 1'b0; cfg_bit = ~cfg_bit;
  endtask

  task automatic pulse_arm();
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  // present one word; fired holds trig_fire seen with it
  task automatic word(input int d, output bit fired);
    @(negedge clk);
    s_valid = 1'b1; s_data = W'(d);
    #1 fired = trig_fire;
    @(posedge clk);
    #1 s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic int grid(input int idx, input int lvl);
    int v;
    if (idx < 16)       v = idx * 17;
    else if (idx == 16) v = lvl - 1;
    else if (idx == 17) v = lvl;
    else                v = lvl + 1;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  initial begin
    bit f;
    int lv[5] = '{0, 1, 128, 254, 255};
    int a, b, expf, gap;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 armed after reset", trig_armed, 0);
    check("R10 ready after reset", s_ready, 1);
    // reset config: level 0, falling; unarmed so no fire
    word(200, f); word(0, f);
    check("R10 no fire while unarmed", f, 0);

    for (int s = 0; s < 2; s++) begin
      for (int li = 0; li < 5; li++) begin
        load_cfg(s[0], lv[li]);
        for (int ia = 0; ia < 19; ia++) begin
          for (int ib = 0; ib < 19; ib++) begin
            a = grid(ia, lv[li]);
            b = grid(ib, lv[li]);
            gap = (ia + ib) % 3;
            if (s == 0) expf = (a >= lv[li] && b < lv[li]) ? 1 : 0;
            else        expf = (a <= lv[li] && b > lv[li]) ? 1 : 0;
            pulse_arm();
            word(a, f);
            check("R6 first word quiet", f, 0);
            idle(gap);  // R9 gaps
            word(b, f);
            check(s == 0 ? "R3/R5 falling pair (R3)" : "R4/R5 rising pair (R4)", f, expf);
            #1 check("R7 armed after pair", trig_armed, expf ? 0 : 1);
          end
        end
      end
    end

    // R7: after fire, further crossings ignored until re-arm
    load_cfg(1'b1, 100);
    pulse_arm();
    word(50, f); word(150, f);
    check("R7 rising fires", f, 1);
    word(50, f); word(150, f);
    check("R7 no refire while disarmed", f, 0);
    check("R7 stays disarmed", trig_armed, 0);
    pulse_arm();
    word(50, f); word(150, f);
    check("R7 fires again after arm", f, 1);

    // R8: pulse lasts one clock
    pulse_arm();
    word(100, f); word(101, f);
    check("R8 fire with word", f, 1);
    #4 check("R8 fire drops after word", trig_fire, 0);

    // R10: word with arm discarded
    pulse_arm();
    @(negedge clk); arm = 1'b1; s_valid = 1'b1; s_data = 8'd10;
    @(negedge clk); arm = 1'b0; s_valid = 1'b0;
    word(200, f);
    check("R10 arm-cycle word not history", f, 0);
    word(10, f); word(200, f);
    check("R10 later crossing fires", f, 1);

    // R1: config holds when cfg_bit toggles without shift
    load_cfg(1'b0, 60);
    @(negedge clk); cfg_bit = 1'b1;
    repeat (3) @(negedge clk);
    cfg_bit = 1'b0;
    pulse_arm();
    word(60, f); word(59, f);
    check("R1 falling at level 60", f, 1);
    // R2: unsigned: 255 is above 60, no signed wrap
    pulse_arm();
    word(59, f); word(255, f);
    check("R2 no falling fire on upward move", f, 0);
    word(60, f); word(255, f);
    check("R2 still armed", trig_armed, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule